// File: doc/BRIEF.md
# Scalable CAN Acceptance Filter Bank

This block decides whether one received CAN frame is accepted by a single acceptance filter bank. The bank is configured by eight 8-bit registers. A 2-bit scale code decides how those bytes are split into filters. The split can be one 32-bit filter pair, two 16-bit groups, four 8-bit groups, or a 16-bit lower half with an 8-bit upper half. Each half of the bank has its own mode bit. In mask mode an identifier byte is paired with a mask byte. In list mode every byte group is a separate exact-match identifier.

The identifier, IDE and RTR bits of the incoming frame are arranged into a fixed 32-bit comparison image. Every filter the configuration defines is compared against that image. One clock after a frame is presented, the block reports whether any filter in the bank accepted it and gives the local number of the filter that accepted it. Filters are numbered in register order, the lower half first. When several filters accept the frame, the lowest number wins. The result is then indexed into a wider numbering by the surrounding controller.

Top module: `fbk_filter_bank`

## Requirements
- R1: The scale code selects the layout: 2'b11 gives 32-bit filters, 2'b10 gives 16-bit filters in both halves, 2'b01 gives a 16-bit lower half with 8-bit upper half, and 2'b00 gives 8-bit filters in both halves. Filters are numbered from 0 in register order, the lower half (registers 1–4) first. A mask/identifier pair counts as one filter.
- R2: A 32-bit filter compares a 32-bit image. Image byte 1 is std_id[10:3]. Image byte 2 is {std_id[2:0], RTR, IDE, ext_id[17:15]}. Image byte 3 is ext_id[14:7]. Image byte 4 is {ext_id[6:0], 0}, and its lowest bit is never compared.
- R3: A 16-bit filter compares only image bytes 1 and 2.
- R4: An 8-bit filter compares only image byte 1. All other frame bits have no effect on it.
- R5: In mask mode, the first byte group of each pair is the identifier and the second is the mask. A mask bit of 1 requires equality, and a mask bit of 0 makes that bit don't care.
- R6: In list mode, every byte group is an identifier on its own, and all of its compared bits must equal the frame.
- R7: mode_lo sets the mode of registers 1–4 and mode_hi sets the mode of registers 5–8, each independently (1 = list, 0 = mask). In 32-bit scale the mode bits must be equal, and mode_lo is the one used.
- R8: When the frame's IDE is 0, the extended identifier bits (ext_id[17:0]) are not compared by any filter. The IDE bit itself is still compared.
- R9: While bank_on is 0, no frame is ever accepted.
- R10: When more than one filter accepts a frame, res_num reports the lowest filter number.
- R11: A frame presented with frm_vld high is answered in the next cycle with res_vld high. res_hit and res_num hold their values in cycles without frm_vld. After reset, res_vld, res_hit and res_num are all 0.
- R12: When a frame is rejected, res_num is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bytes | input | 64 | Filter registers; register k+1 sits at bits [8k+7:8k] |
| scale | input | 2 | Scale code of the bank |
| mode_lo | input | 1 | Mode of registers 1–4 (1 = list, 0 = mask) |
| mode_hi | input | 1 | Mode of registers 5–8 (1 = list, 0 = mask) |
| bank_on | input | 1 | Bank activation |
| frm_vld | input | 1 | A frame is presented this cycle |
| frm_std_id | input | 11 | Standard identifier, or extended identifier bits 28:18 |
| frm_ext_id | input | 18 | Extended identifier bits 17:0 |
| frm_ide | input | 1 | Frame identifier extension bit |
| frm_rtr | input | 1 | Frame remote request bit |
| res_vld | output | 1 | Result of the previous cycle's frame is valid |
| res_hit | output | 1 | Frame accepted by the bank |
| res_num | output | 3 | Local number of the accepting filter |

## Verification
The assertions assume that the configuration and the frame fields are stable and known whenever frm_vld is high. They also assume that mode_lo equals mode_hi whenever the scale code is 2'b11. In that scale the filter count the checker expects is derived from mode_lo alone. The random stimulus draws mode_hi independently only for the three smaller scales and copies mode_lo into it for the 32-bit scale. It changes inputs only away from the sampling edge. Frames are often built from four consecutive configuration bytes, so that accepting paths get exercised and not only rejections.

// File: rtl/fbk_pkg.sv
package fbk_pkg;
  localparam int BYTES  = 8;
  localparam int HALF   = BYTES / 2;
  localparam int SLOTS  = 8;
  localparam int NUM_W  = $clog2(SLOTS);
  localparam int STD_W  = 11;
  localparam int EXT_W  = 18;
  localparam int IMG_W  = 32;
  localparam int IMG_B  = IMG_W / 8;

  typedef logic [IMG_W-1:0]         img_t;
  typedef logic [BYTES-1:0][7:0]    cfg_t;

  typedef enum logic [1:0] {
    SC_8    = 2'b00,
    SC_16_8 = 2'b01,
    SC_16   = 2'b10,
    SC_32   = 2'b11
  } scale_e;

  typedef struct packed {
    logic en;
    img_t id;
    img_t care;
  } slot_t;

  // Frame fields arranged as the comparison image, byte 1 at the top.
  function automatic img_t frame_image(logic [STD_W-1:0] sid, logic [EXT_W-1:0] eid,
                                       logic rtr, logic ide);
    return {sid, rtr, ide, eid, 1'b0};
  endfunction

  // Bits that take part in a comparison for the given IDE value.
  function automatic img_t compare_scope(logic ide);
    img_t s;
    s = ide ? '1 : {{(STD_W + 2){1'b1}}, {(IMG_W - STD_W - 2){1'b0}}};
    return s;
  endfunction

  // Bits covered by a filter element of nb bytes.
  function automatic img_t width_mask(int nb);
    img_t m;
    case (nb)
      4:       m = {{(IMG_W - 1){1'b1}}, 1'b0};
      2:       m = {{16{1'b1}}, {(IMG_W - 16){1'b0}}};
      default: m = {{8{1'b1}}, {(IMG_W - 8){1'b0}}};
    endcase
    return m;
  endfunction

  // nb bytes starting at register index first, left aligned in an image word.
  function automatic img_t take_elem(cfg_t c, int first, int nb);
    img_t e;
    e = '0;
    for (int j = 0; j < IMG_B; j++) begin
      if (j < nb) e[IMG_W-1-8*j -: 8] = c[(first + j) % BYTES];
    end
    return e;
  endfunction
endpackage

// File: rtl/fbk_layout.sv
module fbk_layout
  import fbk_pkg::*;
(
  input  cfg_t                 cfg,
  input  scale_e               scale,
  input  logic                 mode_lo,
  input  logic                 mode_hi,
  output slot_t [SLOTS-1:0]    slots
);
  always_comb begin
    logic [NUM_W:0] n;
    int   g_nb;
    int   g_span;
    int   g_base;
    logic g_list;
    logic g_on;
    img_t wm;
    slots = '0;
    n     = '0;
    for (int g = 0; g < 2; g++) begin
      g_on   = (g == 0) || (scale != SC_32);
      g_base = g * HALF;
      g_span = (scale == SC_32) ? BYTES : HALF;
      g_list = (g == 0 || scale == SC_32) ? mode_lo : mode_hi;
      if (scale == SC_32)  g_nb = 4;
      else if (g == 0)     g_nb = (scale == SC_8) ? 1 : 2;
      else                 g_nb = (scale == SC_16) ? 2 : 1;
      wm = width_mask(g_nb);
      for (int k = 0; k < BYTES; k++) begin
        if (g_on && g_list && (k * g_nb < g_span)) begin
          slots[n[NUM_W-1:0]] = '{en: 1'b1,
                                  id: take_elem(cfg, g_base + k * g_nb, g_nb),
                                  care: wm};
          n = n + 1'b1;
        end else if (g_on && !g_list && (2 * k * g_nb < g_span)) begin
          slots[n[NUM_W-1:0]] = '{en: 1'b1,
                                  id: take_elem(cfg, g_base + 2 * k * g_nb, g_nb),
                                  care: wm & take_elem(cfg, g_base + (2 * k + 1) * g_nb, g_nb)};
          n = n + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fbk_cmp.sv
module fbk_cmp
  import fbk_pkg::*;
(
  input  slot_t slot,
  input  img_t  img,
  input  img_t  scope,
  output logic  hit
);
  assign hit = slot.en && (((img ^ slot.id) & slot.care & scope) == '0);
endmodule

// File: rtl/fbk_prio.sv
module fbk_prio #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/fbk_filter_bank.sv
module fbk_filter_bank
  import fbk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BYTES*8-1:0] cfg_bytes,
  input  logic [1:0]         scale,
  input  logic               mode_lo,
  input  logic               mode_hi,
  input  logic               bank_on,
  input  logic               frm_vld,
  input  logic [STD_W-1:0]   frm_std_id,
  input  logic [EXT_W-1:0]   frm_ext_id,
  input  logic               frm_ide,
  input  logic               frm_rtr,
  output logic               res_vld,
  output logic               res_hit,
  output logic [NUM_W-1:0]   res_num
);
  cfg_t              cfg;
  scale_e            sc;
  slot_t [SLOTS-1:0] slots;
  img_t              frame_img;
  img_t              cmp_scope;
  logic [SLOTS-1:0]  slot_en;
  logic [SLOTS-1:0]  slot_hit;
  logic              any_hit;
  logic [NUM_W-1:0]  low_idx;
  logic              acc_hit;

  assign cfg       = cfg_t'(cfg_bytes);
  assign sc        = scale_e'(scale);
  assign frame_img = frame_image(frm_std_id, frm_ext_id, frm_rtr, frm_ide);
  assign cmp_scope = compare_scope(frm_ide);

  fbk_layout u_layout (
    .cfg     (cfg),
    .scale   (sc),
    .mode_lo (mode_lo),
    .mode_hi (mode_hi),
    .slots   (slots)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign slot_en[i] = slots[i].en;
    fbk_cmp u_cmp (
      .slot  (slots[i]),
      .img   (frame_img),
      .scope (cmp_scope),
      .hit   (slot_hit[i])
    );
  end

  fbk_prio #(.N(SLOTS)) u_prio (
    .req (slot_hit),
    .any (any_hit),
    .idx (low_idx)
  );

  assign acc_hit = any_hit && bank_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_hit <= 1'b0;
      res_num <= '0;
    end else begin
      res_vld <= frm_vld;
      if (frm_vld) begin
        res_hit <= acc_hit;
        res_num <= acc_hit ? low_idx : '0;
      end
    end
  end
endmodule

// File: rtl/fbk_filter_bank_chk.sv
module fbk_filter_bank_chk
  import fbk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       scale,
  input logic             mode_lo,
  input logic             mode_hi,
  input logic             bank_on,
  input logic             frm_vld,
  input logic             res_vld,
  input logic             res_hit,
  input logic [NUM_W-1:0] res_num,
  input logic [SLOTS-1:0] slot_en,
  input logic [SLOTS-1:0] slot_hit
);
  // Filter count per half, stated as a table of scale and mode.
  function automatic int expect_count(logic [1:0] s, logic ml, logic mh);
    int lo;
    int hi;
    case (s)
      2'b11:   begin lo = ml ? 2 : 1; hi = 0; end
      2'b10:   begin lo = ml ? 2 : 1; hi = mh ? 2 : 1; end
      2'b01:   begin lo = ml ? 2 : 1; hi = mh ? 4 : 2; end
      default: begin lo = ml ? 4 : 2; hi = mh ? 4 : 2; end
    endcase
    return lo + hi;
  endfunction

  // R1: number of filters defined by the layout
  p_filter_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_en) == expect_count(scale, mode_lo, mode_hi));

  // R1: only defined filters may accept
  p_hit_within_defined_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_hit & ~slot_en) == '0);

  p_inactive_rejects_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld && !bank_on |=> !res_hit);

  p_hit_follows_filters_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld && bank_on |=> res_hit == ($past(slot_hit) != '0));

  p_first_filter_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld && bank_on && slot_hit[0] |=> res_num == '0);

  p_result_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |=> res_vld);

  p_no_spurious_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> !res_vld);

  p_result_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> $stable(res_hit) && $stable(res_num));

  p_miss_num_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && !res_hit |-> res_num == '0);
endmodule

bind fbk_filter_bank fbk_filter_bank_chk u_chk (.*);

// File: tb/tb_fbk_filter_bank.sv
`timescale 1ns/1ps
module tb_fbk_filter_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cfg_bytes = '0;
  logic [1:0]  scale = 2'b11;
  logic        mode_lo = 1'b0;
  logic        mode_hi = 1'b0;
  logic        bank_on = 1'b0;
  logic        frm_vld = 1'b0;
  logic [10:0] frm_std_id = '0;
  logic [17:0] frm_ext_id = '0;
  logic        frm_ide = 1'b0;
  logic        frm_rtr = 1'b0;
  logic        res_vld;
  logic        res_hit;
  logic [2:0]  res_num;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fbk_filter_bank dut (.*);

  function automatic logic [63:0] pack8(logic [7:0] r1, logic [7:0] r2, logic [7:0] r3,
                                        logic [7:0] r4, logic [7:0] r5, logic [7:0] r6,
                                        logic [7:0] r7, logic [7:0] r8);
    return {r8, r7, r6, r5, r4, r3, r2, r1};
  endfunction

  function automatic bit fmatch(logic [63:0] c, logic [7:0] im [4], logic [7:0] scp [4],
                                int idb, int mi, int nb);
    for (int j = 0; j < nb; j++) begin
      logic [7:0] cb, mb, s;
      cb = c[8*(idb+j) +: 8];
      mb = (mi < 0) ? 8'hFF : c[8*(mi+j) +: 8];
      s  = scp[j];
      if (j == 3) s = s & 8'hFE;
      if (((im[j] ^ cb) & mb & s) != 8'h00) return 1'b0;
    end
    return 1'b1;
  endfunction

  // Expected filter number, or -1 for a rejected frame.
  function automatic int ref_eval(logic [63:0] c, logic [1:0] sc, logic ml, logic mh,
                                  logic on, logic [10:0] sid, logic [17:0] eid,
                                  logic ide, logic rtr);
    logic [7:0] im [4];
    logic [7:0] scp [4];
    int num = 0;
    int res = -1;
    im[0] = sid[10:3];
    im[1] = {sid[2:0], rtr, ide, eid[17:15]};
    im[2] = eid[14:7];
    im[3] = {eid[6:0], 1'b0};
    scp[0] = 8'hFF;
    scp[1] = ide ? 8'hFF : 8'hF8;
    scp[2] = ide ? 8'hFF : 8'h00;
    scp[3] = ide ? 8'hFF : 8'h00;
    for (int g = 0; g < 2; g++) begin
      int base, nb, span, step;
      logic lst;
      if (g == 1 && sc == 2'b11) continue;
      base = 4 * g;
      if (sc == 2'b11) begin nb = 4; span = 8; lst = ml; end
      else if (g == 0) begin nb = (sc == 2'b00) ? 1 : 2; span = 4; lst = ml; end
      else begin nb = (sc == 2'b10) ? 2 : 1; span = 4; lst = mh; end
      step = lst ? nb : 2 * nb;
      for (int p = 0; p < span; p += step) begin
        if (res < 0 && fmatch(c, im, scp, base + p, lst ? -1 : base + p + nb, nb)) res = num;
        num++;
      end
    end
    return on ? res : -1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_img(logic [31:0] w);
    frm_std_id = w[31:21];
    frm_rtr    = w[20];
    frm_ide    = w[19];
    frm_ext_id = w[18:1];
  endtask

  // Present one frame, then check the registered answer one cycle later.
  task automatic send(string req, int exp);
    int e2;
    e2 = ref_eval(cfg_bytes, scale, mode_lo, mode_hi, bank_on, frm_std_id, frm_ext_id,
                  frm_ide, frm_rtr);
    if (exp == -2) exp = e2;
    else chk(req, "model", e2, exp);
    frm_vld = 1'b1;
    @(negedge clk);
    frm_vld = 1'b0;
    chk("R11", "res_vld", int'(res_vld), 1);
    chk(req, "res_hit", int'(res_hit), (exp >= 0) ? 1 : 0);
    chk(req, "res_num", int'(res_num), (exp >= 0) ? exp : 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R11", "reset res_vld", int'(res_vld), 0);
    chk("R11", "reset res_hit", int'(res_hit), 0);
    chk("R12", "reset res_num", int'(res_num), 0);
    rst_n = 1'b1;
    @(negedge clk);
    bank_on = 1'b1;

    // 32-bit mask, full mask: exact frame accepted by filter 0
    scale = 2'b11; mode_lo = 0; mode_hi = 0;
    cfg_bytes = pack8(8'h12, 8'h3C, 8'h56, 8'h78, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    set_img(32'h123C_5678);
    send("R2", 0);
    // mask byte 4 cleared: a difference there is don't care
    cfg_bytes = pack8(8'h12, 8'h3C, 8'h56, 8'h78, 8'hFF, 8'hFF, 8'hFF, 8'h00);
    set_img(32'h123C_5600);
    send("R5", 0);
    set_img(32'h123C_5778);
    send("R5", -1);
    // no match reports number 0
    set_img(32'h0000_0000);
    send("R12", -1);
    // 32-bit list: second identifier accepts
    mode_lo = 1; mode_hi = 1;
    cfg_bytes = pack8(8'h11, 8'h19, 8'h11, 8'h10, 8'h12, 8'h3C, 8'h56, 8'h78);
    set_img(32'h123C_5678);
    send("R6", 1);
    // standard frame: extended bits differ yet accepted
    mode_lo = 0; mode_hi = 0;
    cfg_bytes = pack8(8'hAB, 8'hE0, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    set_img(32'hABE5_5A5A);
    send("R8", 0);
    set_img(32'hABE8_0000);
    send("R8", -1);
    // inactive bank
    cfg_bytes = pack8(8'h12, 8'h3C, 8'h56, 8'h78, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    set_img(32'h123C_5678);
    bank_on = 0;
    send("R9", -1);
    bank_on = 1;
    // 16-bit list in both halves, last filter accepts
    scale = 2'b10; mode_lo = 1; mode_hi = 1;
    cfg_bytes = pack8(8'h01, 8'h00, 8'h02, 8'h00, 8'h03, 8'h00, 8'hA5, 8'h20);
    set_img(32'hA520_0000);
    send("R3", 3);
    // 16/8: lower mask, upper list; 8-bit ignores bytes 2..4
    scale = 2'b01; mode_lo = 0; mode_hi = 1;
    cfg_bytes = pack8(8'h77, 8'h77, 8'hFF, 8'hFF, 8'h01, 8'h02, 8'h03, 8'hA5);
    set_img(32'hA5FF_1234);
    send("R4", 4);
    // 8-bit list, two matches: lowest number wins
    scale = 2'b00; mode_lo = 1; mode_hi = 1;
    cfg_bytes = pack8(8'h10, 8'h20, 8'hA5, 8'h30, 8'h40, 8'hA5, 8'h50, 8'h60);
    set_img(32'hA500_0000);
    send("R10", 2);
    // halves choose their mode independently
    mode_lo = 0; mode_hi = 1;
    cfg_bytes = pack8(8'h00, 8'hFF, 8'h00, 8'hFF, 8'h11, 8'h22, 8'hA5, 8'h33);
    send("R7", 4);
    mode_lo = 1; mode_hi = 0;
    send("R7", 5);
    // result holds in an idle cycle
    @(negedge clk);
    chk("R11", "idle res_vld", int'(res_vld), 0);
    chk("R11", "hold res_hit", int'(res_hit), 1);
    chk("R11", "hold res_num", int'(res_num), 5);

    for (int it = 0; it < 400; it++) begin
      logic [31:0] w;
      int off;
      scale   = 2'($urandom);
      mode_lo = 1'($urandom);
      mode_hi = (scale == 2'b11) ? mode_lo : 1'($urandom);
      bank_on = ($urandom % 8) != 0;
      cfg_bytes = {$urandom, $urandom};
      if ($urandom % 4 == 0) cfg_bytes = cfg_bytes | {$urandom, $urandom};
      off = $urandom % 8;
      for (int j = 0; j < 4; j++) w[31-8*j -: 8] = cfg_bytes[8*((off + j) % 8) +: 8];
      if ($urandom % 5 == 0) w = $urandom;
      set_img(w);
      send("R1", -2);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule